// File: doc/BRIEF.md
# Serial Transmitter with Enable Preamble

The block is the transmit half of an asynchronous serial port, controlled by a small host write port. The host writes a control byte and a data word. The transmitter frames each data word with one start bit and one stop bit and shifts it out on a serial data line. It also drives a companion clock line that pulses once in each data bit. Both lines have their own output enable, so the host can release them to high impedance when the transmitter is switched off.

When the enable bit is switched on, the line is first filled with a run of ones that lasts one whole frame. Any pending data follows after that run. When the enable is switched off in the middle of a frame, the frame still completes before the lines are released. If the enable is switched off and back on during one frame, a fresh run of ones follows that frame. Two flags are set by the hardware: data register empty and transmission complete. Each flag is gated by its own enable bit into a single interrupt request. A send-break bit replaces data with all-zero frames.

Top module: `sertx_preamble`

## Requirements
- R1: After synchronous reset the control register reads 0x00, data-empty and transmit-complete read 1, both output enables are 0 and the interrupt request is 0.
- R2: A data frame is a 0 start bit, then the data bits LSB first (8 from wr_data, or 9 with wr_d8 as the ninth when nine_bit is 1), then a 1 stop bit. Each bit lasts TICKS_PER_BIT baud ticks.
- R3: Writing control bit 3 (enable) from 0 to 1 drives the lines and first sends a run of ones lasting one frame length: 10 bit times in 8-bit mode, 11 in 9-bit mode. A pending data frame follows at once.
- R4: After the run of ones with no data pending, the data line stays driven high while the enable remains 1, and both flags read 1.
- R5: Clearing the enable during a frame lets that frame finish. Both output enables drop in the cycle the stop bit ends, and transmit-complete is 1 at that point.
- R6: Clearing and then setting the enable within one frame finishes that frame and then sends a new run of ones of one frame length. Only after that run does transmit-complete set.
- R7: A data write (wr_addr = 1) clears both flags. Data-empty sets again when the word moves into the shifter. Transmit-complete sets when the shifter goes quiet with nothing pending.
- R8: The interrupt request equals (data-empty AND control bit 7) OR (transmit-complete AND control bit 6). It is updated in the same cycle as the flags.
- R9: The clock line is low during the first half of each data bit. It is high during start, stop, preamble and idle. Its enable follows the data enable.
- R10: While control bit 0 (break) is 1, frames of all zeros follow one another. After it clears, the current zero frame completes, then at least one 1 bit is sent before the line goes idle.
- R11: A data word written while the enable is 0 is held and not sent, and the lines stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One pulse per baud divider period |
| nine_bit | input | 1 | Selects 9 data bits per frame |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects data |
| wr_data | input | 8 | Write data (control byte or low data bits) |
| wr_d8 | input | 1 | Ninth data bit, taken on data writes |
| ctrl_o | output | 8 | Control register contents |
| tdre_o | output | 1 | Data register empty flag |
| tc_o | output | 1 | Transmission complete flag |
| irq_o | output | 1 | Interrupt request |
| txd_o | output | 1 | Serial data value |
| txd_oe_o | output | 1 | Serial data output enable |
| sclk_o | output | 1 | Bit clock value |
| sclk_oe_o | output | 1 | Bit clock output enable |

## Verification
The bench builds the block with TICKS_PER_BIT = 4 and DATA_BITS = 8, and holds the baud tick high, so every bit lasts four clocks. At that size the bench can send all 256 byte values and 64 nine-bit patterns as frames. It can also check, to the exact cycle, the length of the run of ones, when the lines are released, when transmit-complete sets after a re-enable, and how long a break lasts. It also covers every combination of the two interrupt enables in each of the three flag states.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_IDLE, ST_PRE, ST_DATA, ST_BRK, ST_STOP
  } tx_state_e;

  localparam int CTL_TIE  = 7;
  localparam int CTL_TCIE = 6;
  localparam int CTL_TE   = 3;
  localparam int CTL_SBK  = 0;
endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
  import sertx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 wr_d8,
  input  logic                 load_pulse,
  input  logic                 tc_set,
  output logic [7:0]           ctl_q,
  output logic [DATA_BITS:0]   data_q,
  output logic                 tdre,
  output logic                 tc,
  output logic                 te_rise,
  output logic                 irq
);
  logic wr_ctl, wr_dat;
  logic tdre_n, tc_n;
  logic [7:0] ctl_n;

  assign wr_ctl = wr_en && !wr_addr;
  assign wr_dat = wr_en && wr_addr;

  always_comb begin
    ctl_n  = wr_ctl ? wr_data : ctl_q;
    tdre_n = wr_dat ? 1'b0 : (load_pulse ? 1'b1 : tdre);
    tc_n   = wr_dat ? 1'b0 : (tc_set ? 1'b1 : tc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      data_q  <= '0;
      tdre    <= 1'b1;
      tc      <= 1'b1;
      te_rise <= 1'b0;
      irq     <= 1'b0;
    end else begin
      te_rise <= wr_ctl && wr_data[CTL_TE] && !ctl_q[CTL_TE];
      ctl_q   <= ctl_n;
      if (wr_dat) data_q <= {wr_d8, wr_data[DATA_BITS-1:0]};
      tdre    <= tdre_n;
      tc      <= tc_n;
      irq     <= (tdre_n && ctl_n[CTL_TIE]) || (tc_n && ctl_n[CTL_TCIE]);
    end
  end

  p_wr_clears_flags_r7: assert property (@(posedge clk) disable iff (rst)
    wr_dat |=> (!tdre && !tc));
  p_load_sets_tdre_r7: assert property (@(posedge clk) disable iff (rst)
    (load_pulse && !wr_dat) |=> tdre);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    irq == ((tdre && ctl_q[CTL_TIE]) || (tc && ctl_q[CTL_TCIE])));
endmodule

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  output logic bit_done,
  output logic first_half
);
  localparam int CW = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF = CW'(TICKS_PER_BIT / 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign bit_done   = tick && (cnt == LAST);
  assign first_half = cnt < HALF;

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 te,
  input  logic                 sbk,
  input  logic                 te_rise,
  input  logic                 nine,
  input  logic                 tdre,
  input  logic [DATA_BITS:0]   data,
  input  logic                 bit_done,
  input  logic                 first_half,
  output logic                 restart,
  output logic                 load_data,
  output logic                 tc_set,
  output logic                 txd,
  output logic                 txd_oe,
  output logic                 sclk,
  output logic                 sclk_oe
);
  localparam int FRAME_MAX = DATA_BITS + 3;
  localparam int LW = $clog2(FRAME_MAX + 1);

  tx_state_e state, nxt;
  logic [FRAME_MAX-1:0] shreg, mask, ld_bits, ld_mask;
  logic [LW-1:0] left, ld_left, len_cur;
  logic pre_pend, active, last_bit, go;

  assign len_cur  = nine ? LW'(FRAME_MAX) : LW'(FRAME_MAX - 1);
  assign active   = (state == ST_PRE) || (state == ST_DATA) ||
                    (state == ST_BRK) || (state == ST_STOP);
  assign last_bit = active && bit_done && (left == LW'(1));

  always_comb begin
    nxt = state;
    go  = 1'b0;
    if (last_bit || state == ST_IDLE || state == ST_OFF) begin
      if (state == ST_BRK)         nxt = (sbk && te) ? ST_BRK : ST_STOP;
      else if (pre_pend || te_rise) nxt = ST_PRE;
      else if (!te)                nxt = ST_OFF;
      else if (sbk)                nxt = ST_BRK;
      else if (!tdre)              nxt = ST_DATA;
      else                         nxt = ST_IDLE;
      go = (nxt != ST_IDLE) && (nxt != ST_OFF);
    end
  end

  assign restart   = go;
  assign load_data = go && (nxt == ST_DATA);
  assign tc_set    = last_bit && ((nxt == ST_IDLE) || (nxt == ST_OFF));

  always_comb begin
    ld_bits = '1;
    ld_mask = '0;
    ld_left = len_cur;
    for (int i = 0; i < DATA_BITS; i++) ld_mask[i+1] = 1'b1;
    if (nine) ld_mask[DATA_BITS+1] = 1'b1;
    unique case (nxt)
      ST_DATA: begin
        ld_bits[0] = 1'b0;
        for (int i = 0; i < DATA_BITS; i++) ld_bits[i+1] = data[i];
        if (nine) ld_bits[DATA_BITS+1] = data[DATA_BITS];
      end
      ST_BRK:  ld_bits = '0;
      ST_STOP: begin ld_mask = '0; ld_left = LW'(1); end
      default: ld_mask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OFF;
      shreg    <= '1;
      mask     <= '0;
      left     <= '0;
      pre_pend <= 1'b0;
    end else begin
      pre_pend <= (pre_pend || te_rise) && !(go && nxt == ST_PRE);
      state    <= nxt;
      if (go) begin
        shreg <= ld_bits;
        mask  <= ld_mask;
        left  <= ld_left;
      end else if (active && bit_done) begin
        shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
        mask  <= {1'b0, mask[FRAME_MAX-1:1]};
        left  <= left - 1'b1;
      end
    end
  end

  assign txd     = active ? shreg[0] : 1'b1;
  assign txd_oe  = (state != ST_OFF);
  assign sclk    = !(active && mask[0] && first_half);
  assign sclk_oe = (state != ST_OFF);

  p_release_at_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(txd_oe) |-> $past(state == ST_IDLE || (bit_done && left == LW'(1))));
  p_break_low_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BRK) |-> !txd);
  p_pre_no_clock_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE) |-> (sclk && txd));
  p_pre_length_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_PRE) |-> (left == $past(len_cur)));
endmodule

// File: rtl/sertx_preamble.sv
module sertx_preamble
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_BITS     = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       nine_bit,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       wr_d8,
  output logic [7:0] ctrl_o,
  output logic       tdre_o,
  output logic       tc_o,
  output logic       irq_o,
  output logic       txd_o,
  output logic       txd_oe_o,
  output logic       sclk_o,
  output logic       sclk_oe_o
);
  logic [7:0] ctl_q;
  logic [DATA_BITS:0] data_q;
  logic tdre, tc, te_rise, irq;
  logic load_data, tc_set, restart, bit_done, first_half;

  sertx_regs #(.DATA_BITS(DATA_BITS)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_d8(wr_d8), .load_pulse(load_data),
    .tc_set(tc_set), .ctl_q(ctl_q), .data_q(data_q), .tdre(tdre),
    .tc(tc), .te_rise(te_rise), .irq(irq)
  );

  sertx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) timer_i (
    .clk(clk), .rst(rst), .restart(restart), .tick(baud_tick),
    .bit_done(bit_done), .first_half(first_half)
  );

  sertx_shifter #(.DATA_BITS(DATA_BITS)) shift_i (
    .clk(clk), .rst(rst), .te(ctl_q[CTL_TE]), .sbk(ctl_q[CTL_SBK]),
    .te_rise(te_rise), .nine(nine_bit), .tdre(tdre), .data(data_q),
    .bit_done(bit_done), .first_half(first_half), .restart(restart),
    .load_data(load_data), .tc_set(tc_set), .txd(txd_o),
    .txd_oe(txd_oe_o), .sclk(sclk_o), .sclk_oe(sclk_oe_o)
  );

  assign ctrl_o = ctl_q;
  assign tdre_o = tdre;
  assign tc_o   = tc;
  assign irq_o  = irq;
endmodule

// File: tb/sertx_preamble_tb_top.sv
module sertx_preamble_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPB = 4;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick = 1'b1;
  logic nine_bit = 1'b0;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_d8 = 1'b0;
  logic [7:0] ctrl_o;
  logic tdre_o, tc_o, irq_o, txd_o, txd_oe_o, sclk_o, sclk_oe_o;

  int checks = 0;
  int errors = 0;
  int lows = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sertx_preamble #(.TICKS_PER_BIT(TPB), .DATA_BITS(8)) dut_i (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .nine_bit(nine_bit),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_d8(wr_d8),
    .ctrl_o(ctrl_o), .tdre_o(tdre_o), .tc_o(tc_o), .irq_o(irq_o),
    .txd_o(txd_o), .txd_oe_o(txd_oe_o), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o)
  );

  always @(negedge clk) if (!rst && sclk_oe_o && !sclk_o) lows++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input logic d8);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_d8 = d8;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start();
    while (txd_o !== 1'b0) @(negedge clk);
  endtask

  task automatic cap(input int nd, output logic [8:0] got, output logic stopb);
    got = '0;
    repeat (TPB/2) @(negedge clk);
    for (int k = 0; k < nd; k++) begin
      repeat (TPB) @(negedge clk);
      got[k] = txd_o;
    end
    repeat (TPB) @(negedge clk);
    stopb = txd_o;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [8:0] got;
    logic stopb;
    int n, t, l0, zeros;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 tdre", tdre_o, 1);
    chk("R1 tc", tc_o, 1);
    chk("R1 txd_oe", txd_oe_o, 0);
    chk("R1 sclk_oe", sclk_oe_o, 0);
    chk("R1 irq", irq_o, 0);

    // R8 flags both 1, enables swept, transmitter off
    for (int e = 0; e < 4; e++) begin
      wr(1'b0, 8'(e << 6), 1'b0);
      chk("R8 ctrl readback", ctrl_o, e << 6);
      chk("R8 irq both flags", irq_o, (e != 0) ? 1 : 0);
    end
    // R11 data held while disabled
    wr(1'b1, 8'h5A, 1'b0);
    chk("R7 write clears tdre", tdre_o, 0);
    chk("R7 write clears tc", tc_o, 0);
    repeat (3*TPB) @(negedge clk);
    chk("R11 lines released", txd_oe_o, 0);
    chk("R11 data not consumed", tdre_o, 0);
    for (int e = 0; e < 4; e++) begin
      wr(1'b0, 8'(e << 6), 1'b0);
      chk("R8 irq no flags", irq_o, 0);
    end

    // R3 preamble then pending frame, 8-bit mode
    wr(1'b0, 8'h08, 1'b0);
    l0 = lows; n = 0;
    while (txd_o !== 1'b0) begin
      if (txd_oe_o) n++;
      @(negedge clk);
    end
    chk("R3 preamble length 8-bit", n, 10*TPB);
    chk("R9 no clock in preamble", lows - l0, 0);
    cap(8, got, stopb);
    chk("R3 frame after preamble", int'(got[7:0]), 'h5A);
    chk("R2 stop bit", stopb, 1);
    while (tc_o !== 1'b1) @(negedge clk);

    // R2 / R7 / R8 / R9 sweep of all byte values
    for (int v = 0; v < 256; v++) begin
      if (v < 4) begin
        wr(1'b0, 8'((v << 6) | 8'h08), 1'b0);
        chk("R8 irq idle flags", irq_o, (v != 0) ? 1 : 0);
      end
      wr(1'b1, 8'(v), 1'b0);
      if (v < 4) chk("R8 irq after write", irq_o, 0);
      wait_start();
      l0 = lows;
      cap(8, got, stopb);
      chk("R2 data 8-bit", int'(got[7:0]), v);
      chk("R2 stop 8-bit", stopb, 1);
      chk("R9 clock lows per frame", lows - l0, 8*TPB/2);
      if (v < 4) begin
        chk("R7 tdre after load", tdre_o, 1);
        chk("R7 tc during frame", tc_o, 0);
        chk("R8 irq in frame", irq_o, (v >> 1) & 1);
      end
      while (tc_o !== 1'b1) @(negedge clk);
      if (v < 4) chk("R8 irq after frame", irq_o, (v != 0) ? 1 : 0);
    end
    wr(1'b0, 8'h08, 1'b0);

    // R5 enable cleared mid-frame
    wr(1'b1, 8'hA5, 1'b0);
    wait_start();
    t = 0;
    repeat (2*TPB) begin @(negedge clk); t++; end
    wr(1'b0, 8'h00, 1'b0); t += 2;
    while (txd_oe_o === 1'b1) begin @(negedge clk); t++; end
    chk("R5 release at frame end", t, 10*TPB);
    chk("R5 tc at release", tc_o, 1);
    chk("R9 clock enable released", sclk_oe_o, 0);
    repeat (5*TPB) @(negedge clk);
    chk("R5 stays released", txd_oe_o, 0);

    // R4 preamble with nothing pending
    wr(1'b0, 8'h08, 1'b0);
    repeat (30*TPB) @(negedge clk);
    chk("R4 line driven", txd_oe_o, 1);
    chk("R4 line high", txd_o, 1);
    chk("R4 tdre", tdre_o, 1);
    chk("R4 tc", tc_o, 1);

    // R6 clear then set within one frame
    wr(1'b1, 8'h3C, 1'b0);
    wait_start();
    t = 0; n = 0;
    repeat (2*TPB) begin @(negedge clk); t++; end
    wr(1'b0, 8'h00, 1'b0); t += 2;
    wr(1'b0, 8'h08, 1'b0); t += 2;
    while (tc_o !== 1'b1) begin
      if (!txd_oe_o) n++;
      @(negedge clk); t++;
    end
    chk("R6 tc after new preamble", t, 2*10*TPB);
    chk("R6 lines never released", n, 0);

    // R2 / R3 nine-bit mode
    wr(1'b0, 8'h00, 1'b0);
    nine_bit = 1'b1;
    wr(1'b1, 8'hC3, 1'b1);
    wr(1'b0, 8'h08, 1'b0);
    n = 0;
    while (txd_o !== 1'b0) begin
      if (txd_oe_o) n++;
      @(negedge clk);
    end
    chk("R3 preamble length 9-bit", n, 11*TPB);
    cap(9, got, stopb);
    chk("R2 data 9-bit after preamble", int'(got), 'h1C3);
    while (tc_o !== 1'b1) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      int exp;
      exp = ((i & 1) << 8) | ((i*37 + 11) & 255);
      wr(1'b1, 8'((i*37 + 11) & 255), 1'(i & 1));
      wait_start();
      l0 = lows;
      cap(9, got, stopb);
      chk("R2 data 9-bit", int'(got), exp);
      chk("R2 stop 9-bit", stopb, 1);
      chk("R9 clock lows 9-bit", lows - l0, 9*TPB/2);
      while (tc_o !== 1'b1) @(negedge clk);
    end

    // R10 single break frame
    wr(1'b0, 8'h09, 1'b0);
    wait_start();
    t = 0;
    repeat (5) begin @(negedge clk); t++; end
    wr(1'b0, 8'h08, 1'b0); t += 2;
    while (txd_o !== 1'b1) begin @(negedge clk); t++; end
    chk("R10 single break length", t, 11*TPB);
    zeros = 0;
    repeat (3*TPB) begin @(negedge clk); if (txd_o !== 1'b1) zeros++; end
    chk("R10 line high after break", zeros, 0);
    chk("R10 line driven", txd_oe_o, 1);

    // R10 break held over two frames
    wr(1'b0, 8'h09, 1'b0);
    wait_start();
    t = 0;
    repeat (11*TPB + 3) begin @(negedge clk); t++; end
    wr(1'b0, 8'h08, 1'b0); t += 2;
    while (txd_o !== 1'b1) begin @(negedge clk); t++; end
    chk("R10 double break length", t, 22*TPB);
    while (tc_o !== 1'b1) @(negedge clk);
    chk("R10 tc after stop", txd_o, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule